// File: doc/BRIEF.md
# Low-Power Quiesce Handshake Controller

This block is the processor-side controller that brings bus snooping to an orderly stop before the core enters a nap or sleep power-saving state. When the core asks for a low-power state, the block raises a quiesce request toward the system. It then holds the core awake until the system answers with a quiesce acknowledge. Only after that answer does it report that the core may power down, and it removes the snoop enable.

While the core is powered down, the system can wake it briefly for snooping. To do this, the system drops the acknowledge and keeps it low for a programmable minimum number of consecutive bus clocks, 8 by default. The block then re-enables snooping. When the system raises the acknowledge again, the block returns the core to nap, even if the original request was for sleep. While a nap is pending, requested or in progress, a pending internal interrupt abandons the request on any cycle. The block then drops the quiesce request and permits the exception-vector fetch in that same cycle. Withdrawing the core's low-power request from any state returns the block to run.

Top module: `quiesce_ctrl`

## Requirements
- R1: The quiesce request output (qreq_o) is high whenever power_down_o is high, and it rises at least one cycle before power_down_o does.
- R2: power_down_o rises only on a clock edge at which qack_i was sampled high.
- R3: While power_down_o is high, snoop_en_o is low.
- R4: While powered down, snoop_en_o rises (and power_down_o falls) only after qack_i has been sampled low on QACK_LOW_MIN (default 8) consecutive edges. The change happens on the edge that samples the last of those lows.
- R5: While snooping is re-enabled (qreq_o high, power_down_o low after a wake), qack_i sampled high returns the block to the powered-down state on the next edge. snoop_en_o then goes low and sleep_o goes low (the state becomes nap).
- R6: With a nap request (lp_mode_i = 0) in progress, sampling irq_pend_i high drops qreq_o on the next edge from the wait, powered-down or snooping states. A sleep request (lp_mode_i = 1) ignores irq_pend_i. While irq_pend_i is high, a new request is not started.
- R7: exc_fetch_ok_o is a one-cycle pulse that is high in the same cycle that qreq_o first reads low after an interrupt abort, and it is high at no other time.
- R8: A qack_i low run shorter than QACK_LOW_MIN clears the run counter. snoop_en_o stays low, and a fresh full run is needed afterwards.
- R9: After reset the block is in run, with qreq_o = 0, snoop_en_o = 1, power_down_o = 0, sleep_o = 0 and exc_fetch_ok_o = 0.
- R10: lp_req_i sampled low in any state sets qreq_o, power_down_o and sleep_o low and snoop_en_o high on the next edge.
- R11: sleep_o is high exactly when power_down_o is high and the current request is sleep (lp_mode_i = 1, latched when the request starts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_req_i | input | 1 | Core requests a low-power state |
| lp_mode_i | input | 1 | Requested state: 0 nap, 1 sleep |
| irq_pend_i | input | 1 | Internal interrupt pending |
| qack_i | input | 1 | Quiesce acknowledge from the system |
| qreq_o | output | 1 | Quiesce request to the system |
| snoop_en_o | output | 1 | Core may snoop bus transactions |
| power_down_o | output | 1 | Core may power down |
| sleep_o | output | 1 | Powered-down state is sleep rather than nap |
| exc_fetch_ok_o | output | 1 | Exception-vector fetch may start |

## Verification
The assertions check the following on every cycle:
- power down implies a quiesce request and no snooping;
- power down starts only after an acknowledge;
- a snoop wake is preceded by a full run of low acknowledges, measured by a counter in the checker;
- a withdrawn request returns to run;
- the fetch pulse coincides with a low request after a sampled interrupt.

Only the directed scenarios can show the rest:
- interrupted short low runs really restart the count;
- sleep ignores the interrupt while nap honours it, from each pending state;
- a wake that started from sleep comes back as nap;
- a new request is held off while the interrupt stays pending.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_SNP  = 2'd3
  } qc_state_e;

  typedef enum logic {
    MODE_NAP   = 1'b0,
    MODE_SLEEP = 1'b1
  } qc_mode_e;
endpackage

// File: rtl/qc_low_timer.sv
module qc_low_timer #(
  parameter int unsigned LOW_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic qack_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LOW_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(LOW_MIN - 1);

  logic [CW-1:0] cnt_q;

  // final low sample of the run
  assign expired_o = arm_i && !qack_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i || qack_i || expired_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qc_fsm.sv
module qc_fsm
  import qc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lp_req_i,
  input  logic      lp_mode_i,
  input  logic      irq_pend_i,
  input  logic      qack_i,
  input  logic      low_expired_i,
  output qc_state_e state_o,
  output qc_mode_e  mode_o,
  output logic      abort_o
);
  qc_state_e state_q, state_d;
  qc_mode_e  mode_q, mode_d;
  logic      abort_q, abort_d;
  logic      nap_irq;

  assign nap_irq = irq_pend_i && (mode_q == MODE_NAP);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    abort_d = 1'b0;
    if (state_q == ST_RUN) begin
      if (lp_req_i && !irq_pend_i) begin
        state_d = ST_WAIT;
        mode_d  = qc_mode_e'(lp_mode_i);
      end
    end else if (!lp_req_i) begin
      state_d = ST_RUN;
    end else if (nap_irq) begin
      state_d = ST_RUN;
      abort_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_WAIT: if (qack_i) state_d = ST_LOW;
        ST_LOW:  if (low_expired_i) state_d = ST_SNP;
        ST_SNP: begin
          if (qack_i) begin
            state_d = ST_LOW;
            mode_d  = MODE_NAP;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      mode_q  <= MODE_NAP;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      abort_q <= abort_d;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/quiesce_ctrl.sv
module quiesce_ctrl
  import qc_pkg::*;
#(
  parameter int unsigned QACK_LOW_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_req_i,
  input  logic lp_mode_i,
  input  logic irq_pend_i,
  input  logic qack_i,
  output logic qreq_o,
  output logic snoop_en_o,
  output logic power_down_o,
  output logic sleep_o,
  output logic exc_fetch_ok_o
);
  qc_state_e state;
  qc_mode_e  mode;
  logic      low_expired;
  logic      abort;

  qc_low_timer #(.LOW_MIN(QACK_LOW_MIN)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (state == ST_LOW),
    .qack_i    (qack_i),
    .expired_o (low_expired)
  );

  qc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lp_req_i      (lp_req_i),
    .lp_mode_i     (lp_mode_i),
    .irq_pend_i    (irq_pend_i),
    .qack_i        (qack_i),
    .low_expired_i (low_expired),
    .state_o       (state),
    .mode_o        (mode),
    .abort_o       (abort)
  );

  assign qreq_o         = (state != ST_RUN);
  assign power_down_o   = (state == ST_LOW);
  assign snoop_en_o     = (state != ST_LOW);
  assign sleep_o        = (state == ST_LOW) && (mode == MODE_SLEEP);
  assign exc_fetch_ok_o = abort;
endmodule

// File: rtl/quiesce_ctrl_chk.sv
module quiesce_ctrl_chk #(
  parameter int unsigned QACK_LOW_MIN = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lp_req_i,
  input logic irq_pend_i,
  input logic qack_i,
  input logic qreq_o,
  input logic snoop_en_o,
  input logic power_down_o,
  input logic exc_fetch_ok_o
);
  localparam int unsigned CW = $clog2(QACK_LOW_MIN + 2);
  logic [CW-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (qack_i) low_run_q <= '0;
    else if (low_run_q < CW'(QACK_LOW_MIN)) low_run_q <= low_run_q + 1'b1;
  end

  // R1
  pd_has_qreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |-> qreq_o);
  // R1
  qreq_before_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(power_down_o) |-> $past(qreq_o));
  // R2
  pd_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(power_down_o) |-> $past(qack_i));
  // R3
  pd_no_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |-> !snoop_en_o);
  // R4
  wake_low_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(snoop_en_o) && qreq_o) |-> (low_run_q >= CW'(QACK_LOW_MIN)));
  // R10
  withdraw_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_req_i |=> (!qreq_o && snoop_en_o && !power_down_o));
  // R7
  fetch_qreq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fetch_ok_o |-> (!qreq_o && $past(irq_pend_i) && $past(qreq_o)));
endmodule

bind quiesce_ctrl quiesce_ctrl_chk #(.QACK_LOW_MIN(QACK_LOW_MIN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lp_req_i       (lp_req_i),
  .irq_pend_i     (irq_pend_i),
  .qack_i         (qack_i),
  .qreq_o         (qreq_o),
  .snoop_en_o     (snoop_en_o),
  .power_down_o   (power_down_o),
  .exc_fetch_ok_o (exc_fetch_ok_o)
);

// File: tb/quiesce_ctrl_tb.sv
module quiesce_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOWN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_req = 1'b0, lp_mode = 1'b0, irq = 1'b0, qack = 1'b0;
  logic qreq, snoop_en, pd, slp, exc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quiesce_ctrl #(.QACK_LOW_MIN(LOWN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_req), .lp_mode_i(lp_mode),
    .irq_pend_i(irq), .qack_i(qack), .qreq_o(qreq), .snoop_en_o(snoop_en),
    .power_down_o(pd), .sleep_o(slp), .exc_fetch_ok_o(exc)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  // expected {qreq, snoop_en, pd, sleep, exc}
  task automatic expect_out(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {qreq, snoop_en, pd, slp, exc};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {qreq,snoop,pd,sleep,exc} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic enter_low(logic mode);
    lp_mode = mode; lp_req = 1'b1; qack = 1'b0;
    tick();
    expect_out("R1", 5'b11000);
    tick(3);
    expect_out("R2", 5'b11000);
    qack = 1'b1;
    tick();
    expect_out("R11", {3'b101, mode, 1'b0});
  endtask

  task automatic t_reset();
    expect_out("R9", 5'b01000);
  endtask

  task automatic t_nap_wake();
    enter_low(1'b0);
    expect_out("R3", 5'b10100);
    qack = 1'b0;
    tick(LOWN - 1);
    expect_out("R8", 5'b10100);
    qack = 1'b1;
    tick();
    qack = 1'b0;
    tick(LOWN - 1);
    expect_out("R8", 5'b10100);
    tick();
    expect_out("R4", 5'b11000);
    qack = 1'b1;
    tick();
    expect_out("R5", 5'b10100);
    lp_req = 1'b0;
    tick();
    expect_out("R10", 5'b01000);
  endtask

  task automatic t_sleep();
    enter_low(1'b1);
    irq = 1'b1;
    tick(2);
    expect_out("R6", 5'b10110);
    irq = 1'b0;
    qack = 1'b0;
    tick(LOWN);
    expect_out("R4", 5'b11000);
    qack = 1'b1;
    tick();
    expect_out("R5", 5'b10100);
    irq = 1'b1;
    tick();
    expect_out("R7", 5'b01001);
    tick();
    expect_out("R7", 5'b01000);
    tick(2);
    expect_out("R6", 5'b01000);
    irq = 1'b0;
    lp_req = 1'b0;
    tick();
  endtask

  task automatic t_abort_wait();
    lp_mode = 1'b0; lp_req = 1'b1; qack = 1'b0;
    tick(2);
    expect_out("R1", 5'b11000);
    irq = 1'b1;
    tick();
    expect_out("R7", 5'b01001);
    irq = 1'b0;
    tick();
    expect_out("R6", 5'b11000);
    // abort from snooping state
    qack = 1'b1;
    tick();
    qack = 1'b0;
    tick(LOWN);
    expect_out("R4", 5'b11000);
    irq = 1'b1;
    tick();
    expect_out("R7", 5'b01001);
    irq = 1'b0;
    lp_req = 1'b0;
    tick();
    expect_out("R10", 5'b01000);
  endtask

  task automatic t_withdraw_wait();
    lp_mode = 1'b1; lp_req = 1'b1; qack = 1'b0;
    tick();
    lp_req = 1'b0;
    tick();
    expect_out("R10", 5'b01000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_nap_wake();
    t_sleep();
    t_abort_wait();
    t_withdraw_wait();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule